// File: doc/BRIEF.md
# Inbound Message Header Generator

This block builds the two-word, 64-bit descriptor that travels ahead of each inbound message. A message arrives as a run of header beats. The beat flagged as first supplies the routing fields. The block takes a sequence number from a 32-bit counter and looks up scheduling values in a 256-entry table at that point. Once the beat flagged as last is accepted, it presents both descriptor words on a valid/ready output.

The sequence counter is shared with the doorbell path. Each accepted doorbell also draws one value, so messages and doorbells fall into a single ordering space. Software fills the scheduling table through a write port. A set of configuration inputs supplies the tag, tag type, skip length, parse mode and the override bits of the second word.

Only one message is open at a time. While a finished descriptor is waiting to be taken, the header input stalls.

Top module: `msg_hdr_gen`

## Requirements
- R1: Word 0 holds, from bit 63 down: priority [63:62], ID-size flag [61], secondary-match flag [60], ssize [59:56], source ID [55:40], xmbox [39:36], mbox [35:34], letter [33:32], sequence [31:0]. These fields are taken from the first beat, and fields on later beats are ignored.
- R2: The counter resets to 0. When a first beat is accepted, the message takes the current counter value and the counter advances by one.
- R3: An accepted doorbell (`dbell_acc_i`) draws the value shown on `dbell_seq_o` in that cycle, and the counter advances by one.
- R4: When a doorbell and a first beat are accepted in the same cycle, the message takes the current value, the doorbell takes the next value, and the counter advances by two.
- R5: `desc_valid_o` rises in the cycle after the last beat is accepted. A beat that is both first and last forms a complete message.
- R6: When the ID-size flag is 0, word 0 bits [55:48] are 0.
- R7: In a message of more than one beat, xmbox is 0. A single-beat message keeps its xmbox.
- R8: Word 1 holds r [63], pm [57:56], sl [54:48], override bits [45:42], qos [41:39], grp [38:35], rs [34], tag type [33:32] and tag [31:0], with zeros in all other bits. The 7-bit table entry is {qos, grp}. It is addressed by {priority, ID-size, secondary-match, mbox, letter} of the first beat.
- R9: The configuration inputs are sampled when the last beat is accepted.
- R10: Two beats are flagged as protocol errors on `proto_err_o` in their cycle and are ignored: a first beat that arrives while a message is open, and a non-first beat that arrives while no message is open. An ignored beat does not draw a sequence value.
- R11: While `desc_valid_o` is high and `desc_ready_i` is low, both words stay stable and `seg_ready_o` is low, so no beat is accepted.
- R12: The table lookup happens when the first beat is accepted. A table write in that same cycle is seen only by later messages.
- R13: After reset, `desc_valid_o` is 0 and `seg_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| seg_valid_i | input | 1 | Header beat present |
| seg_ready_o | output | 1 | Beat can be accepted |
| seg_first_i | input | 1 | Beat is the first of a message |
| seg_last_i | input | 1 | Beat is the last of a message |
| seg_prio_i | input | 2 | Priority |
| seg_tt_i | input | 1 | 1 for 16-bit IDs |
| seg_dis_i | input | 1 | Destination matched the secondary ID |
| seg_ssize_i | input | 4 | Segment size code |
| seg_sid_i | input | 16 | Source ID |
| seg_xmbox_i | input | 4 | Mailbox extension |
| seg_mbox_i | input | 2 | Mailbox |
| seg_letter_i | input | 2 | Letter |
| dbell_acc_i | input | 1 | Doorbell accepted pulse |
| dbell_seq_o | output | 32 | Sequence value drawn by a doorbell in this cycle |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | 8 | Table write index |
| tbl_qos_i | input | 3 | QoS value to write |
| tbl_grp_i | input | 4 | Group value to write |
| cfg_tag_i | input | 32 | Tag value |
| cfg_tt_i | input | 2 | Tag type |
| cfg_sl_i | input | 7 | Skip length |
| cfg_pm_i | input | 2 | Parse mode |
| cfg_r_i | input | 1 | Raw-form select |
| cfg_rs_i | input | 1 | Buffer-in-descriptor select |
| cfg_novr_i | input | 4 | Override bits {nqos, ngrp, ntt, ntag} |
| desc_valid_o | output | 1 | Descriptor valid |
| desc_ready_i | input | 1 | Descriptor taken |
| desc_w0_o | output | 64 | Word 0 |
| desc_w1_o | output | 64 | Word 1 |
| proto_err_o | output | 1 | Protocol error on this beat |

## Verification
Two outputs are combinational: `proto_err_o` and `dbell_seq_o` are due in the same cycle as the beat or doorbell. The bench reads them a few nanoseconds after driving, before the rising edge. The descriptor words and `desc_valid_o` come from one register and are due one cycle after the last beat. The bench therefore drives on a falling edge and checks them on the next falling edge, after the capturing rising edge. The expected sequence numbers come from a counter kept in the bench. It advances for each accepted first beat and each doorbell, and it never reads the design's state.

// File: rtl/mhg_pkg.sv
package mhg_pkg;
  localparam int SEQ_W  = 32;
  localparam int IDX_W  = 8;
  localparam int QOS_W  = 3;
  localparam int GRP_W  = 4;
  localparam int ENT_W  = QOS_W + GRP_W;
  localparam int WORD_W = 64;

  typedef struct packed {
    logic [1:0]  prio;
    logic        tt;
    logic        dis;
    logic [3:0]  ssize;
    logic [15:0] sid;
    logic [3:0]  xmbox;
    logic [1:0]  mbox;
    logic [1:0]  letter;
  } seg_hdr_t;

  typedef struct packed {
    logic        r;
    logic [1:0]  pm;
    logic [6:0]  sl;
    logic [3:0]  novr;
    logic        rs;
    logic [1:0]  tt;
    logic [31:0] tag;
  } cfg_t;

  function automatic logic [IDX_W-1:0] tbl_index(seg_hdr_t h);
    return {h.prio, h.tt, h.dis, h.mbox, h.letter};
  endfunction

  function automatic logic [WORD_W-1:0] pack_w1(cfg_t c, logic [ENT_W-1:0] ent);
    return {c.r, 5'b0, c.pm, 1'b0, c.sl, 2'b0, c.novr, ent, c.rs, c.tt, c.tag};
  endfunction
endpackage

// File: rtl/mhg_seq_ctr.sv
module mhg_seq_ctr #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         msg_take_i,
  input  logic         db_take_i,
  output logic [W-1:0] msg_seq_o,
  output logic [W-1:0] db_seq_o
);
  logic [W-1:0] cnt_q;

  assign msg_seq_o = cnt_q;
  assign db_seq_o  = cnt_q + {{(W-1){1'b0}}, msg_take_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + {{(W-1){1'b0}}, msg_take_i} + {{(W-1){1'b0}}, db_take_i};
  end

  // R4: doorbell ordered behind a message taken in the same cycle
  p_db_after_msg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_take_i && db_take_i) |-> (db_seq_o == msg_seq_o + 1'b1));

  // R2, R3: the counter never moves without a consumer
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msg_take_i && !db_take_i) |=> $stable(msg_seq_o));
endmodule

// File: rtl/mhg_sched_tbl.sv
module mhg_sched_tbl #(
  parameter int IDX_W = 8,
  parameter int ENT_W = 7
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [ENT_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [ENT_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // Read returns pre-write contents in a write cycle
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mhg_msg_track.sv
module mhg_msg_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic first_i,
  input  logic last_i,
  output logic start_o,
  output logic end_o,
  output logic err_o
);
  logic open_q;

  assign start_o = acc_i & first_i & ~open_q;
  assign end_o   = acc_i & last_i & (first_i ? ~open_q : open_q);
  assign err_o   = acc_i & (first_i ? open_q : ~open_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 open_q <= 1'b0;
    else if (start_o && !last_i) open_q <= 1'b1;
    else if (end_o)              open_q <= 1'b0;
  end

  // R10: a stray first beat neither closes nor restarts the open message
  p_err_keeps_open_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && first_i && open_q) |=> open_q);

  p_start_end_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!start_o && !end_o));
endmodule

// File: rtl/msg_hdr_gen.sv
module msg_hdr_gen
  import mhg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        seg_valid_i,
  output logic        seg_ready_o,
  input  logic        seg_first_i,
  input  logic        seg_last_i,
  input  logic [1:0]  seg_prio_i,
  input  logic        seg_tt_i,
  input  logic        seg_dis_i,
  input  logic [3:0]  seg_ssize_i,
  input  logic [15:0] seg_sid_i,
  input  logic [3:0]  seg_xmbox_i,
  input  logic [1:0]  seg_mbox_i,
  input  logic [1:0]  seg_letter_i,
  input  logic        dbell_acc_i,
  output logic [31:0] dbell_seq_o,
  input  logic        tbl_we_i,
  input  logic [7:0]  tbl_addr_i,
  input  logic [2:0]  tbl_qos_i,
  input  logic [3:0]  tbl_grp_i,
  input  logic [31:0] cfg_tag_i,
  input  logic [1:0]  cfg_tt_i,
  input  logic [6:0]  cfg_sl_i,
  input  logic [1:0]  cfg_pm_i,
  input  logic        cfg_r_i,
  input  logic        cfg_rs_i,
  input  logic [3:0]  cfg_novr_i,
  output logic        desc_valid_o,
  input  logic        desc_ready_i,
  output logic [63:0] desc_w0_o,
  output logic [63:0] desc_w1_o,
  output logic        proto_err_o
);
  logic             acc, msg_start, msg_end;
  logic [SEQ_W-1:0] msg_seq;
  logic [ENT_W-1:0] tbl_rd;
  seg_hdr_t         hdr_in, hdr_q, hdr_cur;
  logic [SEQ_W-1:0] seq_q, seq_cur;
  logic [ENT_W-1:0] ent_q, ent_cur;
  cfg_t             cfg;
  logic             valid_q;
  logic [WORD_W-1:0] w0_q, w1_q;

  assign seg_ready_o = ~valid_q;
  assign acc         = seg_valid_i & seg_ready_o;

  // Fixups: narrow IDs clear sid upper byte; multi-beat clears xmbox
  always_comb begin
    hdr_in = '{prio: seg_prio_i, tt: seg_tt_i, dis: seg_dis_i, ssize: seg_ssize_i,
               sid: seg_sid_i, xmbox: seg_xmbox_i, mbox: seg_mbox_i, letter: seg_letter_i};
    if (!seg_tt_i)   hdr_in.sid[15:8] = 8'h00;
    if (!seg_last_i) hdr_in.xmbox     = 4'h0;
  end

  assign cfg = '{r: cfg_r_i, pm: cfg_pm_i, sl: cfg_sl_i, novr: cfg_novr_i,
                 rs: cfg_rs_i, tt: cfg_tt_i, tag: cfg_tag_i};

  mhg_msg_track u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (acc),
    .first_i (seg_first_i),
    .last_i  (seg_last_i),
    .start_o (msg_start),
    .end_o   (msg_end),
    .err_o   (proto_err_o)
  );

  mhg_seq_ctr #(.W(SEQ_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .msg_take_i (msg_start),
    .db_take_i  (dbell_acc_i),
    .msg_seq_o  (msg_seq),
    .db_seq_o   (dbell_seq_o)
  );

  mhg_sched_tbl #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_tbl (
    .clk_i   (clk_i),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i ({tbl_qos_i, tbl_grp_i}),
    .raddr_i (tbl_index(hdr_in)),
    .rdata_o (tbl_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q <= '0;
      seq_q <= '0;
      ent_q <= '0;
    end else if (msg_start) begin
      hdr_q <= hdr_in;
      seq_q <= msg_seq;
      ent_q <= tbl_rd;
    end
  end

  // Single-beat messages bypass the capture registers
  assign hdr_cur = msg_start ? hdr_in  : hdr_q;
  assign seq_cur = msg_start ? msg_seq : seq_q;
  assign ent_cur = msg_start ? tbl_rd  : ent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      w0_q    <= '0;
      w1_q    <= '0;
    end else if (msg_end) begin
      valid_q <= 1'b1;
      w0_q    <= {hdr_cur, seq_cur};
      w1_q    <= pack_w1(cfg, ent_cur);
    end else if (valid_q && desc_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign desc_valid_o = valid_q;
  assign desc_w0_o    = w0_q;
  assign desc_w1_o    = w1_q;

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && !desc_ready_i) |=> (desc_valid_o && $stable(desc_w0_o) && $stable(desc_w1_o)));

  p_valid_after_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_end |=> desc_valid_o);

  p_sid_narrow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && !desc_w0_o[61]) |-> (desc_w0_o[55:48] == 8'h00));

  p_no_accept_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && seg_valid_i) |-> (!msg_start && !msg_end && !proto_err_o));
endmodule

// File: tb/msg_hdr_gen_tb.sv
module msg_hdr_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        seg_valid = 0, seg_first = 0, seg_last = 0;
  logic [31:0] seg_hdr = '0;
  logic        dbell = 0;
  logic        tbl_we = 0;
  logic [7:0]  tbl_addr = '0;
  logic [6:0]  tbl_data = '0;
  logic [31:0] cfg_tag = 32'hCAFE_0123;
  logic [1:0]  cfg_tt = 2'd2, cfg_pm = 2'd1;
  logic [6:0]  cfg_sl = 7'd8;
  logic        cfg_r = 1'b1, cfg_rs = 1'b0;
  logic [3:0]  cfg_novr = 4'b0000;
  logic        desc_ready = 0;
  logic        seg_ready, desc_valid, proto_err;
  logic [31:0] dbell_seq;
  logic [63:0] w0, w1;

  msg_hdr_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .seg_valid_i(seg_valid), .seg_ready_o(seg_ready),
    .seg_first_i(seg_first), .seg_last_i(seg_last),
    .seg_prio_i(seg_hdr[31:30]), .seg_tt_i(seg_hdr[29]), .seg_dis_i(seg_hdr[28]),
    .seg_ssize_i(seg_hdr[27:24]), .seg_sid_i(seg_hdr[23:8]), .seg_xmbox_i(seg_hdr[7:4]),
    .seg_mbox_i(seg_hdr[3:2]), .seg_letter_i(seg_hdr[1:0]),
    .dbell_acc_i(dbell), .dbell_seq_o(dbell_seq),
    .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr), .tbl_qos_i(tbl_data[6:4]), .tbl_grp_i(tbl_data[3:0]),
    .cfg_tag_i(cfg_tag), .cfg_tt_i(cfg_tt), .cfg_sl_i(cfg_sl), .cfg_pm_i(cfg_pm),
    .cfg_r_i(cfg_r), .cfg_rs_i(cfg_rs), .cfg_novr_i(cfg_novr),
    .desc_valid_o(desc_valid), .desc_ready_i(desc_ready),
    .desc_w0_o(w0), .desc_w1_o(w1), .proto_err_o(proto_err)
  );

  int checks = 0, errors = 0;
  logic [31:0] exp_seq = 0;
  logic        saw_err;
  logic [31:0] saw_db;
  logic [6:0]  tbl_model [256];
  logic [63:0] w0_hold, w1_hold;

  // Beat fields: {prio[31:30], tt[29], dis[28], ssize[27:24], sid[23:8], xmbox[7:4], mbox[3:2], letter[1:0]}
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    32'hE5AB_CD7E, 32'h4312_3459, 32'h20FF_FF00, 32'hD000_1A93, 32'h1F80_01F6, 32'hBC55_AAFF
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [6:0] tbl_init(input int i);
    return 7'((i * 37 + 11) & 8'h7F);
  endfunction

  function automatic logic [63:0] ew0(input logic [31:0] h, input logic multi, input logic [31:0] s);
    logic [31:0] x = h;
    if (!x[29]) x[23:16] = 8'h00;
    if (multi)  x[7:4]   = 4'h0;
    return {x, s};
  endfunction

  function automatic logic [63:0] ew1(input logic [6:0] ent);
    return {cfg_r, 5'b0, cfg_pm, 1'b0, cfg_sl, 2'b0, cfg_novr, ent, cfg_rs, cfg_tt, cfg_tag};
  endfunction

  function automatic logic [7:0] idx(input logic [31:0] h);
    return {h[31:30], h[29], h[28], h[3:2], h[1:0]};
  endfunction

  // Drive one cycle; combinational outputs sampled before the edge
  task automatic beat(input logic v, input logic f, input logic l, input logic [31:0] h, input logic db);
    @(negedge clk);
    seg_valid = v; seg_first = f; seg_last = l; seg_hdr = h; dbell = db;
    #2;
    saw_err = proto_err;
    saw_db  = dbell_seq;
    @(negedge clk);
    seg_valid = 0; seg_first = 0; seg_last = 0; dbell = 0;
  endtask

  task automatic pop();
    @(negedge clk); desc_ready = 1;
    @(negedge clk); desc_ready = 0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 valid", {63'd0, desc_valid}, 64'd0);
    chk("R13 ready", {63'd0, seg_ready}, 64'd1);
    rst_n = 1;

    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      tbl_we = 1; tbl_addr = 8'(i); tbl_data = tbl_init(i); tbl_model[i] = tbl_init(i);
    end
    @(negedge clk); tbl_we = 0;

    // R1 R2 R5 R6 R8: single-beat vectors
    for (int v = 0; v < NV; v++) begin
      beat(1, 1, 1, VEC[v], 0);
      chk("R5 valid", {63'd0, desc_valid}, 64'd1);
      chk("R1 word0", w0, ew0(VEC[v], 0, exp_seq));
      chk("R8 word1", w1, ew1(tbl_model[idx(VEC[v])]));
      exp_seq++;
      pop();
    end

    // R3 doorbell alone
    beat(0, 0, 0, '0, 1);
    chk("R3 dbell seq", {32'd0, saw_db}, {32'd0, exp_seq});
    exp_seq++;

    // R4 doorbell with first beat
    beat(1, 1, 1, VEC[1], 1);
    chk("R4 dbell seq", {32'd0, saw_db}, {32'd0, exp_seq + 1});
    chk("R4 msg seq", w0, ew0(VEC[1], 0, exp_seq));
    exp_seq += 2;
    pop();
    beat(1, 1, 1, VEC[2], 0);
    chk("R4 next seq", {32'd0, w0[31:0]}, {32'd0, exp_seq});
    exp_seq++;
    pop();

    // R7 R1 multi-beat: xmbox cleared, later fields ignored, doorbell mid-message
    beat(1, 1, 0, VEC[0], 0);
    chk("R5 no early valid", {63'd0, desc_valid}, 64'd0);
    beat(1, 0, 0, VEC[3], 1);
    beat(1, 0, 1, VEC[4], 0);
    chk("R7 multi word0", w0, ew0(VEC[0], 1, exp_seq));
    exp_seq += 2;
    pop();

    // R10 stray first while open, stray middle with none open
    beat(1, 1, 0, VEC[5], 0);
    beat(1, 1, 1, VEC[2], 0);
    chk("R10 err first", {63'd0, saw_err}, 64'd1);
    chk("R10 ignored", {63'd0, desc_valid}, 64'd0);
    beat(1, 0, 1, VEC[3], 0);
    chk("R10 word0", w0, ew0(VEC[5], 1, exp_seq));
    exp_seq++;
    pop();
    beat(1, 0, 1, VEC[1], 0);
    chk("R10 err orphan", {63'd0, saw_err}, 64'd1);
    chk("R10 orphan no desc", {63'd0, desc_valid}, 64'd0);

    // R11 hold while not ready; beats refused
    beat(1, 1, 1, VEC[4], 0);
    exp_seq++;
    w0_hold = w0; w1_hold = w1;
    beat(1, 1, 1, VEC[0], 0);
    chk("R11 ready low", {63'd0, seg_ready}, 64'd0);
    chk("R11 w0 stable", w0, w0_hold);
    chk("R11 w1 stable", w1, w1_hold);
    pop();
    chk("R11 refused beat", {63'd0, desc_valid}, 64'd0);
    beat(1, 1, 1, VEC[0], 0);
    chk("R11 seq unused", {32'd0, w0[31:0]}, {32'd0, exp_seq});
    exp_seq++;
    pop();

    // R12 table write in same cycle as first beat
    @(negedge clk);
    tbl_we = 1; tbl_addr = idx(VEC[3]); tbl_data = ~tbl_model[idx(VEC[3])];
    seg_valid = 1; seg_first = 1; seg_last = 1; seg_hdr = VEC[3];
    @(negedge clk);
    tbl_we = 0; seg_valid = 0; seg_first = 0; seg_last = 0;
    chk("R12 old entry", w1, ew1(tbl_model[idx(VEC[3])]));
    tbl_model[idx(VEC[3])] = ~tbl_model[idx(VEC[3])];
    exp_seq++;
    pop();

    // R9 new configuration, then R12 new entry visible
    cfg_tag = 32'h1357_9BDF; cfg_tt = 2'd1; cfg_sl = 7'd100; cfg_pm = 2'd3;
    cfg_r = 0; cfg_rs = 1; cfg_novr = 4'b1010;
    beat(1, 1, 1, VEC[3], 0);
    chk("R12 new entry", {57'd0, w1[41:35]}, {57'd0, tbl_model[idx(VEC[3])]});
    chk("R9 cfg word1", w1, ew1(tbl_model[idx(VEC[3])]));
    exp_seq++;
    pop();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule